// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

The block moves a parameterised data word (18 bits by default) between two ports, A and B, with an independent path for each direction. Each path has one storage register that the block loads in one of three ways. In flow-through mode the register reloads on every system clock while the path's latch enable is high. In edge mode the register captures once when the path's strobe input rises while latch enable is low. In hold mode it keeps its contents while latch enable is low and the strobe is steady. The strobe and latch-enable inputs are sampled against the fast system clock. A strobe rise is found by comparing the current sample with the one from the previous cycle.

Tri-state pins are split into a value vector and a per-bit drive-enable vector. The A-to-B enable is active high and the B-to-A enable is active low. An optional bus-hold stage sits on each input port. When a bit is marked as not driven, the block sees the last value that was driven on that bit.

Top module: `bus_xcvr`

## Requirements
- R1: While rst_ni is low, b_oe_o and a_oe_o are all zero and b_o and a_o read zero. After reset both storage registers and both bus-hold registers hold zero.
- R2: With ab_le_i high at a system clock edge, b_o takes the A value seen at that edge, one cycle later. This holds whether or not ab_clk_i rises in the same cycle.
- R3: With ab_le_i low and ab_clk_i steady, b_o does not change, whatever a_i does.
- R4: With ab_le_i low, a 0-to-1 change of ab_clk_i between two samples captures the A value at the second sample. A 1-to-0 change captures nothing.
- R5: If ab_le_i falls while ab_clk_i is high, b_o keeps the value it had and no capture occurs.
- R6: b_oe_o is all ones in the same cycle that ab_oe_i is 1 (outside reset) and all zeros when ab_oe_i is 0. The stored value is unaffected.
- R7: a_oe_o is all ones when ba_oe_ni is 0 and all zeros when ba_oe_ni is 1 (active low, outside reset).
- R8: B-to-A flow uses ba_le_i, ba_clk_i and a separate register. Activity on one direction never changes the other direction's output.
- R9: With BUS_HOLD=1, an input bit whose drive flag (a_drv_i or b_drv_i) is 0 is seen as the last value it had while its flag was 1. This works per bit.
- R10: A strobe input that is already high when reset is released causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | WIDTH | Value present on the A pins |
| a_drv_i | input | WIDTH | Per-bit flag: A pin driven by the outside |
| b_i | input | WIDTH | Value present on the B pins |
| b_drv_i | input | WIDTH | Per-bit flag: B pin driven by the outside |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_clk_i | input | 1 | A-to-B capture strobe |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_clk_i | input | 1 | B-to-A capture strobe |
| a_o | output | WIDTH | Value the block drives onto A |
| a_oe_o | output | WIDTH | Per-bit drive enable for A |
| b_o | output | WIDTH | Value the block drives onto B |
| b_oe_o | output | WIDTH | Per-bit drive enable for B |

## Verification
A wrong load selection in a path shows on that path's output one system cycle after the offending edge. A stray capture appears as a new value, and a missed capture leaves the old value in place. A false strobe edge after reset shows as a nonzero output right after release. A bus-hold register that tracks the wrong bits shows as a corrupted word on the opposite port in the cycle after the drive flags drop. Output-enable faults show on the enable vectors at once, with no clock needed.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned WORD_W = 18;

  typedef enum logic [1:0] {
    LD_HOLD = 2'd0,
    LD_FLOW = 2'd1,
    LD_EDGE = 2'd2
  } load_sel_e;
endpackage

// File: rtl/xcvr_edge_detect.sv
module xcvr_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_i;
      armed_q <= 1'b1;
    end
  end

  // no edge until one real sample exists after reset
  assign rise_o = lvl_i & ~lvl_q & armed_q;

  // R4
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int unsigned WIDTH  = 18,
  parameter bit          ENABLE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] in_i,
  input  logic [WIDTH-1:0] drv_i,
  output logic [WIDTH-1:0] val_o
);
  if (ENABLE) begin : g_hold
    logic [WIDTH-1:0] hold_q;

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hold_q[k] <= 1'b0;
        else if (drv_i[k]) hold_q[k] <= in_i[k];
      end

      assign val_o[k] = drv_i[k] ? in_i[k] : hold_q[k];

      // R9
      keep_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drv_i[k] |=> (drv_i[k] || val_o[k] == $past(in_i[k])));
    end
  end else begin : g_plain
    logic unused;
    assign unused = ^{drv_i, clk_i, rst_ni};
    assign val_o  = in_i;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH         = WORD_W,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic             le_i,
  input  logic             strobe_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [WIDTH-1:0] oe_o
);
  logic             rise;
  logic             oe_en;
  load_sel_e        sel;
  logic [WIDTH-1:0] store_q;

  xcvr_edge_detect u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (strobe_i),
    .rise_o (rise)
  );

  // latch enable wins over a coincident strobe edge
  always_comb begin
    if (le_i)      sel = LD_FLOW;
    else if (rise) sel = LD_EDGE;
    else           sel = LD_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
    end else begin
      case (sel)
        LD_FLOW, LD_EDGE: store_q <= din_i;
        default:          store_q <= store_q;
      endcase
    end
  end

  if (OE_ACTIVE_LOW) begin : g_oe_low
    assign oe_en = ~oe_i;
  end else begin : g_oe_high
    assign oe_en = oe_i;
  end

  assign oe_o   = {WIDTH{oe_en & rst_ni}};
  assign dout_o = store_q;

  // R2
  flow_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> dout_o == $past(din_i));

  // R4
  edge_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && rise) |=> dout_o == $past(din_i));

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise) |=> $stable(dout_o));
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH    = WORD_W,
  parameter bit          BUS_HOLD = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] a_drv_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] b_drv_i,
  input  logic             ab_oe_i,
  input  logic             ab_le_i,
  input  logic             ab_clk_i,
  input  logic             ba_oe_ni,
  input  logic             ba_le_i,
  input  logic             ba_clk_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] a_oe_o,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] b_oe_o
);
  localparam int unsigned NDIR = 2;  // 0: A to B, 1: B to A

  logic [WIDTH-1:0] pin_val [NDIR];
  logic [WIDTH-1:0] pin_drv [NDIR];
  logic [WIDTH-1:0] seen    [NDIR];
  logic [WIDTH-1:0] dout    [NDIR];
  logic [WIDTH-1:0] oe      [NDIR];
  logic             le      [NDIR];
  logic             strobe  [NDIR];
  logic             oe_in   [NDIR];

  assign pin_val[0] = a_i;      assign pin_val[1] = b_i;
  assign pin_drv[0] = a_drv_i;  assign pin_drv[1] = b_drv_i;
  assign le[0]      = ab_le_i;  assign le[1]      = ba_le_i;
  assign strobe[0]  = ab_clk_i; assign strobe[1]  = ba_clk_i;
  assign oe_in[0]   = ab_oe_i;  assign oe_in[1]   = ba_oe_ni;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_bus_hold #(
      .WIDTH  (WIDTH),
      .ENABLE (BUS_HOLD)
    ) u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (pin_val[d]),
      .drv_i  (pin_drv[d]),
      .val_o  (seen[d])
    );

    xcvr_lane #(
      .WIDTH         (WIDTH),
      .OE_ACTIVE_LOW (d == 1)
    ) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .din_i    (seen[d]),
      .le_i     (le[d]),
      .strobe_i (strobe[d]),
      .oe_i     (oe_in[d]),
      .dout_o   (dout[d]),
      .oe_o     (oe[d])
    );
  end

  assign b_o    = dout[0];
  assign b_oe_o = oe[0];
  assign a_o    = dout[1];
  assign a_oe_o = oe[1];

  // R8
  ab_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && !ab_clk_i) |=> $stable(b_o));
endmodule

// File: tb/tb_bus_xcvr.sv
module tb_bus_xcvr;
  localparam int unsigned W = 18;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, a_drv_i = '1, b_i = '0, b_drv_i = '1;
  logic         ab_oe_i = 1'b1, ab_le_i = 1'b0, ab_clk_i = 1'b0;
  logic         ba_oe_ni = 1'b1, ba_le_i = 1'b0, ba_clk_i = 1'b0;
  logic [W-1:0] a_o, a_oe_o, b_o, b_oe_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bus_xcvr #(.WIDTH(W), .BUS_HOLD(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_i(a_i), .a_drv_i(a_drv_i), .b_i(b_i), .b_drv_i(b_drv_i),
    .ab_oe_i(ab_oe_i), .ab_le_i(ab_le_i), .ab_clk_i(ab_clk_i),
    .ba_oe_ni(ba_oe_ni), .ba_le_i(ba_le_i), .ba_clk_i(ba_clk_i),
    .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  // {le, strobe, a, expected b after one clock}
  localparam logic [2*W+1:0] VEC [12] = '{
    {1'b1, 1'b0, 18'h12345, 18'h12345},  // R2
    {1'b1, 1'b0, 18'h2AAAA, 18'h2AAAA},  // R2
    {1'b0, 1'b0, 18'h3FFFF, 18'h2AAAA},  // R3
    {1'b0, 1'b1, 18'h15555, 18'h15555},  // R4 rise
    {1'b0, 1'b1, 18'h00F0F, 18'h15555},  // R3 strobe held high
    {1'b0, 1'b0, 18'h0F0F0, 18'h15555},  // R4 fall ignored
    {1'b0, 1'b1, 18'h0F0F0, 18'h0F0F0},  // R4 rise
    {1'b1, 1'b1, 18'h11111, 18'h11111},  // R2
    {1'b0, 1'b1, 18'h22222, 18'h11111},  // R5 le falls, strobe high
    {1'b0, 1'b1, 18'h33333, 18'h11111},  // R5
    {1'b1, 1'b0, 18'h00001, 18'h00001},  // R2
    {1'b1, 1'b1, 18'h3FFFF, 18'h3FFFF}   // R2 le with rise
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state, enable requested but suppressed
    ba_oe_ni = 1'b0;
    #1;
    check("R1 b_oe", b_oe_o, '0);
    check("R1 a_oe", a_oe_o, '0);
    check("R1 b_o", b_o, '0);
    check("R1 a_o", a_o, '0);
    ba_oe_ni = 1'b1;
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < 12; i++) begin
      ab_le_i  = VEC[i][2*W+1];
      ab_clk_i = VEC[i][2*W];
      a_i      = VEC[i][2*W-1:W];
      tick();
      check($sformatf("R2-table step %0d", i), b_o, VEC[i][W-1:0]);
    end
    // R8 reverse path untouched by A-to-B traffic
    check("R8 a_o idle", a_o, '0);

    // R6 output enable, value unaffected
    ab_le_i = 1'b0; ab_clk_i = 1'b0;
    ab_oe_i = 1'b0; #1;
    check("R6 b_oe off", b_oe_o, '0);
    check("R6 value kept", b_o, 18'h3FFFF);
    ab_oe_i = 1'b1; #1;
    check("R6 b_oe on", b_oe_o, '1);

    // R7 active-low enable
    ba_oe_ni = 1'b0; #1;
    check("R7 a_oe on", a_oe_o, '1);
    ba_oe_ni = 1'b1; #1;
    check("R7 a_oe off", a_oe_o, '0);

    // R8 B to A flow, A to B held
    ba_le_i = 1'b1; b_i = 18'h0ABCD;
    tick();
    check("R8 a_o flow", a_o, 18'h0ABCD);
    check("R8 b_o kept", b_o, 18'h3FFFF);
    ba_le_i = 1'b0; b_i = 18'h00000;
    tick();
    check("R8 a_o held", a_o, 18'h0ABCD);

    // R9 bus hold
    ab_le_i = 1'b1; a_drv_i = '1; a_i = 18'h2AAAA;
    tick();
    check("R9 driven", b_o, 18'h2AAAA);
    a_drv_i = '0; a_i = 18'h15555;
    tick();
    check("R9 all floating", b_o, 18'h2AAAA);
    a_drv_i = 18'h000FF; a_i = 18'h3FFFF;
    tick();
    check("R9 partial", b_o, 18'h2AAFF);
    a_drv_i = '1; ab_le_i = 1'b0;

    // R10 strobe high across reset release
    ab_clk_i = 1'b1;
    rst_ni = 1'b0; #1;
    check("R1 store cleared", b_o, '0);
    tick();
    a_i = 18'h1F1F1;
    rst_ni = 1'b1;
    tick(); tick();
    check("R10 no false capture", b_o, '0);
    ab_clk_i = 1'b0;
    tick();
    ab_clk_i = 1'b1;
    tick();
    check("R4 capture after reset", b_o, 18'h1F1F1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule